// File: doc/BRIEF.md
# MSI Doorbell to Interrupt Pulser

This block is a 4 KB memory-mapped frame that turns message-signalled-interrupt doorbell writes into single-cycle pulses on a bank of interrupt request lines. A device writes an absolute interrupt number into the doorbell register. The frame subtracts its configured window start and pulses the matching output line. Numbers that fall outside the window are dropped without any other effect. Software discovers the window through a read-only type word, and the frame also answers a small set of identification reads. All registers are little-endian 32-bit words.

The window is fixed when the block is elaborated, using two parameters: `BASE_OFS` and `NUM_LINES`. The first served interrupt number is `BASE_OFS + 32`. The bus side is a simple request/response port. Ready is held high, every request is answered exactly one cycle later, and a sticky error flag records any access with an illegal size or an unmapped offset.

Top module: `msi_doorbell_frame`

## Requirements
- R1: While synchronous active-high reset is applied, and on the cycle after it is released, `irq_pulse`, `rsp_valid`, `rsp_rdata` and `access_err` are all zero.
- R2: `req_ready` is always 1. Each request sampled at a clock edge produces `rsp_valid` = 1 for exactly the following cycle, and `rsp_valid` is 0 after any edge with no request.
- R3: A read of offset 0x008 with `req_size` = 4 returns `((BASE_OFS + 32) << 16) | NUM_LINES`.
- R4: A read of offset 0xFCC with `req_size` = 4 returns 0x0510_0000. The value 0x51 sits in bits [31:20], and all other bits are zero.
- R5: A 4-byte read of any offset from 0xFD0 through 0xFFC returns zero and does not raise `access_err`.
- R6: A write to offset 0x040 with `req_size` of 2 or 4 takes `req_wdata[9:0]` as an interrupt number N and ignores bits [31:10]. If `BASE_OFS + 32 <= N < BASE_OFS + 32 + NUM_LINES`, then bit `N - BASE_OFS - 32` of `irq_pulse` is 1 in the response cycle and 0 in the cycle after it.
- R7: A doorbell write whose number lies outside the window pulses no line and does not raise `access_err`.
- R8: Two doorbell writes to the same in-window number on consecutive cycles give two separate one-cycle pulses on that line. The pulses fall in the first and third cycles after the first write, with a low cycle between them. No line is ever high on two consecutive cycles.
- R9: A read with `req_size` other than 4 returns zero. A write with `req_size` other than 2 or 4 pulses nothing. Either access sets `access_err`.
- R10: A read of an unmapped offset (including 0x040) returns zero and sets `access_err`. A write to any offset other than 0x040 changes nothing and sets `access_err`.
- R11: Once set, `access_err` stays 1 until reset.
- R12: Elaboration fails unless `1 <= NUM_LINES <= 128` and `BASE_OFS + 32 + NUM_LINES <= 1020`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the frame |
| req_size | input | 3 | Access size in bytes (1, 2, 4 legal encodings by value) |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted, held at 1 |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | 32 | Read data, zero for writes and rejected reads |
| irq_pulse | output | NUM_LINES | One-cycle interrupt pulses, one bit per served number |
| access_err | output | 1 | Sticky flag for a bad-size or bad-offset access |

## Verification
On every cycle, the assertions check the response timing, the type word returned by a legal read, the stickiness of the error flag, and that no interrupt line stays high for two cycles in a row. Only the bench's scenarios can show that the right line is selected for each number. The bench does this by sweeping all 1024 numbers over a small window. The same holds for the deferred second pulse of a back-to-back pair, the silent drop of out-of-window numbers, and the error flag being raised by each kind of illegal access and cleared by reset.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

   localparam int unsigned ADDR_W    = 12;
   localparam int unsigned DATA_W    = 32;
   localparam int unsigned NUM_W     = 10;
   localparam int unsigned NUM_SHIFT = 32;
   localparam int unsigned NUM_CEIL  = 1020;
   localparam int unsigned LINE_CAP  = 128;

   localparam logic [ADDR_W-1:0] OFS_TYPE     = 12'h008;
   localparam logic [ADDR_W-1:0] OFS_DOORBELL = 12'h040;
   localparam logic [ADDR_W-1:0] OFS_IDENT    = 12'hFCC;
   localparam logic [ADDR_W-1:0] OFS_ZERO_LO  = 12'hFD0;
   localparam logic [ADDR_W-1:0] OFS_ZERO_HI  = 12'hFFC;

   localparam logic [11:0] IDENT_PRODUCT = 12'h051;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_TYPE,
      SEL_IDENT,
      SEL_ZERO
   } rd_sel_e;

   typedef struct packed {
      logic    rd_ok;
      logic    ring;
      logic    bad;
      rd_sel_e sel;
   } frame_dec_t;

endpackage

// File: rtl/msi_frame_decode.sv
module msi_frame_decode
   import msi_frame_pkg::*;
(
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   output frame_dec_t        dec
);

   logic    rd_size_ok;
   logic    wr_size_ok;
   rd_sel_e map_sel;

   assign rd_size_ok = (size == 3'd4);
   assign wr_size_ok = (size == 3'd2) || (size == 3'd4);

   always_comb begin
      if (addr == OFS_TYPE)
         map_sel = SEL_TYPE;
      else if (addr == OFS_IDENT)
         map_sel = SEL_IDENT;
      else if (addr >= OFS_ZERO_LO && addr <= OFS_ZERO_HI)
         map_sel = SEL_ZERO;
      else
         map_sel = SEL_NONE;
   end

   always_comb begin
      dec = '0;
      dec.sel = SEL_NONE;
      if (valid) begin
         if (write) begin
            if (addr == OFS_DOORBELL && wr_size_ok)
               dec.ring = 1'b1;
            else
               dec.bad = 1'b1;
         end else begin
            if (map_sel != SEL_NONE && rd_size_ok) begin
               dec.rd_ok = 1'b1;
               dec.sel   = map_sel;
            end else begin
               dec.bad = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/msi_id_window.sv
module msi_id_window
   import msi_frame_pkg::*;
#(
   parameter int unsigned FIRST     = 32,
   parameter int unsigned NUM_LINES = 64
) (
   input  logic                 ring,
   input  logic [NUM_W-1:0]     num,
   output logic [NUM_LINES-1:0] hit
);

   localparam int unsigned LAST = FIRST + NUM_LINES;

   logic [31:0]      num_w;
   logic             in_win;
   logic [NUM_W-1:0] local_idx;

   assign num_w     = 32'(num);
   assign in_win    = (num_w >= FIRST) && (num_w < LAST);
   assign local_idx = num - NUM_W'(FIRST);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line_hit
      assign hit[i] = ring && in_win && (local_idx == NUM_W'(i));
   end

endmodule

// File: rtl/msi_pulse_line.sv
module msi_pulse_line (
   input  logic clk,
   input  logic rst,
   input  logic hit,
   output logic pulse
);

   logic pend_q;
   logic pulse_q;
   logic fire;
   logic pend_d;

   assign fire   = (hit || pend_q) && !pulse_q;
   assign pend_d = pend_q ? (hit || !fire) : (hit && !fire);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pend_q  <= pend_d;
         pulse_q <= fire;
      end
   end

   assign pulse = pulse_q;

endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
   import msi_frame_pkg::*;
#(
   parameter int unsigned BASE_OFS  = 0,
   parameter int unsigned NUM_LINES = 64
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [11:0]          req_addr,
   input  logic [2:0]           req_size,
   input  logic [31:0]          req_wdata,
   output logic                 req_ready,
   output logic                 rsp_valid,
   output logic [31:0]          rsp_rdata,
   output logic [NUM_LINES-1:0] irq_pulse,
   output logic                 access_err
);

   localparam int unsigned FIRST = BASE_OFS + NUM_SHIFT;
   localparam logic [DATA_W-1:0] TYPE_WORD =
      (DATA_W'(FIRST) << 16) | DATA_W'(NUM_LINES);
   localparam logic [DATA_W-1:0] IDENT_WORD = {IDENT_PRODUCT, 20'h0_0000};

   // R12: elaboration-time parameter checks
   if (NUM_LINES < 1 || NUM_LINES > LINE_CAP) begin : g_bad_count
      $fatal(1, "msi_doorbell_frame: NUM_LINES out of range");
   end
   if (FIRST + NUM_LINES > NUM_CEIL) begin : g_bad_window
      $fatal(1, "msi_doorbell_frame: window passes highest interrupt number");
   end

   frame_dec_t           dec;
   logic [NUM_LINES-1:0] hit;
   logic [DATA_W-1:0]    rd_word;
   logic                 unused_wdata_hi;

   assign unused_wdata_hi = ^req_wdata[DATA_W-1:NUM_W];

   msi_frame_decode i_decode (
      .valid (req_valid),
      .write (req_write),
      .addr  (req_addr),
      .size  (req_size),
      .dec   (dec)
   );

   msi_id_window #(
      .FIRST     (FIRST),
      .NUM_LINES (NUM_LINES)
   ) i_window (
      .ring (dec.ring),
      .num  (req_wdata[NUM_W-1:0]),
      .hit  (hit)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_pulse
      msi_pulse_line i_line (
         .clk   (clk),
         .rst   (rst),
         .hit   (hit[i]),
         .pulse (irq_pulse[i])
      );
   end

   always_comb begin
      unique case (dec.sel)
         SEL_TYPE:  rd_word = TYPE_WORD;
         SEL_IDENT: rd_word = IDENT_WORD;
         default:   rd_word = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rsp_valid  <= 1'b0;
         rsp_rdata  <= '0;
         access_err <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_rdata  <= dec.rd_ok ? rd_word : '0;
         access_err <= access_err || dec.bad;
      end
   end

   assign req_ready = 1'b1;

endmodule

// File: rtl/msi_doorbell_frame_chk.sv
module msi_doorbell_frame_chk #(
   parameter int unsigned BASE_OFS  = 0,
   parameter int unsigned NUM_LINES = 64
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 req_valid,
   input logic                 req_write,
   input logic [11:0]          req_addr,
   input logic [2:0]           req_size,
   input logic [31:0]          req_wdata,
   input logic                 rsp_valid,
   input logic [31:0]          rsp_rdata,
   input logic [NUM_LINES-1:0] irq_pulse,
   input logic                 access_err
);

   localparam logic [31:0] EXP_TYPE = ((BASE_OFS + 32) << 16) | NUM_LINES;

   logic unused_chk;
   assign unused_chk = ^req_wdata;

   p_resp_follows_r2: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> rsp_valid);

   p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> !rsp_valid);

   p_type_word_r3: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !req_write && req_addr == 12'h008 && req_size == 3'd4)
      |=> (rsp_rdata == EXP_TYPE));

   p_no_stretch_r8: assert property (@(posedge clk) disable iff (rst)
      (|irq_pulse) |=> ((irq_pulse & $past(irq_pulse)) == '0));

   p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
      access_err |=> access_err);

   p_err_has_cause_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(access_err) |-> $past(req_valid));

endmodule

bind msi_doorbell_frame msi_doorbell_frame_chk #(
   .BASE_OFS  (BASE_OFS),
   .NUM_LINES (NUM_LINES)
) i_chk (.*);

// File: tb/test_msi_doorbell_frame.sv
module test_msi_doorbell_frame;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned BASE = 5;
   localparam int unsigned N    = 8;
   localparam int unsigned FIRST = BASE + 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         req_valid = 1'b0;
   logic         req_write = 1'b0;
   logic [11:0]  req_addr = '0;
   logic [2:0]   req_size = '0;
   logic [31:0]  req_wdata = '0;
   logic         req_ready;
   logic         rsp_valid;
   logic [31:0]  rsp_rdata;
   logic [N-1:0] irq_pulse;
   logic         access_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msi_doorbell_frame #(.BASE_OFS(BASE), .NUM_LINES(N)) i_msi_doorbell_frame (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .irq_pulse(irq_pulse), .access_err(access_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic w, input logic [11:0] a, input logic [2:0] s,
                        input logic [31:0] d);
      req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
      @(negedge clk);
   endtask

   task automatic idle();
      req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0; req_wdata = '0;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      idle();
      idle();
      rst = 1'b0;
      idle();
   endtask

   function automatic logic [N-1:0] expect_line(input int unsigned num);
      logic [N-1:0] e = '0;
      if (num >= FIRST && num < FIRST + N) e[num - FIRST] = 1'b1;
      return e;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1: state while in reset
      check("R1 pulse in reset", 32'(irq_pulse), 0);
      check("R1 rsp_valid in reset", 32'(rsp_valid), 0);
      check("R1 err in reset", 32'(access_err), 0);
      rst = 1'b0;
      idle();
      check("R1 pulse after reset", 32'(irq_pulse), 0);
      check("R1 rdata after reset", rsp_rdata, 0);
      check("R2 ready", 32'(req_ready), 1);

      // R3 / R2: type word and response timing
      drive(1'b0, 12'h008, 3'd4, 0);
      check("R2 rsp_valid", 32'(rsp_valid), 1);
      check("R3 type word", rsp_rdata, ((FIRST) << 16) | N);
      idle();
      check("R2 rsp_valid idle", 32'(rsp_valid), 0);

      // R4: identification word
      drive(1'b0, 12'hFCC, 3'd4, 0);
      check("R4 ident", rsp_rdata, 32'h0510_0000);
      idle();

      // R5: zero range
      for (int a = 'hFD0; a <= 'hFFC; a += 4) begin
         drive(1'b0, 12'(a), 3'd4, 0);
         check("R5 zero range", rsp_rdata, 0);
      end
      idle();
      check("R5 no error", 32'(access_err), 0);

      // R6 / R7: sweep every interrupt number, alternating sizes, junk in upper bits
      for (int n = 0; n < 1024; n++) begin
         drive(1'b1, 12'h040, (n % 2 == 1) ? 3'd2 : 3'd4, 32'hA5C0_0000 | 32'(n));
         check((n >= FIRST && n < FIRST + N) ? "R6 pulse" : "R7 dropped",
               32'(irq_pulse), 32'(expect_line(n)));
         idle();
         check("R6 one cycle", 32'(irq_pulse), 0);
      end
      check("R7 no error", 32'(access_err), 0);

      // R8: back-to-back writes, first and last line
      for (int k = 0; k < 2; k++) begin
         int unsigned num = (k == 0) ? FIRST : FIRST + N - 1;
         drive(1'b1, 12'h040, 3'd4, 32'(num));
         check("R8 first pulse", 32'(irq_pulse), 32'(expect_line(num)));
         drive(1'b1, 12'h040, 3'd4, 32'(num));
         check("R8 gap", 32'(irq_pulse), 0);
         idle();
         check("R8 second pulse", 32'(irq_pulse), 32'(expect_line(num)));
         idle();
         check("R8 settled", 32'(irq_pulse), 0);
      end

      // R9: bad read sizes
      for (int s = 0; s < 8; s++) begin
         if (s != 4) begin
            do_reset();
            drive(1'b0, 12'h008, 3'(s), 0);
            check("R9 bad read size data", rsp_rdata, 0);
            idle();
            check("R9 bad read size err", 32'(access_err), 1);
         end
      end
      // R9: bad write sizes
      for (int s = 0; s < 8; s++) begin
         if (s != 2 && s != 4) begin
            do_reset();
            drive(1'b1, 12'h040, 3'(s), 32'(FIRST + 1));
            check("R9 bad write size no pulse", 32'(irq_pulse), 0);
            idle();
            check("R9 bad write size no late pulse", 32'(irq_pulse), 0);
            check("R9 bad write size err", 32'(access_err), 1);
         end
      end

      // R10: unmapped read and write
      do_reset();
      check("R11 cleared by reset", 32'(access_err), 0);
      drive(1'b0, 12'h040, 3'd4, 0);
      check("R10 doorbell read data", rsp_rdata, 0);
      idle();
      check("R10 unmapped read err", 32'(access_err), 1);
      do_reset();
      drive(1'b1, 12'h008, 3'd4, 32'(FIRST));
      check("R10 unmapped write no pulse", 32'(irq_pulse), 0);
      idle();
      check("R10 unmapped write err", 32'(access_err), 1);
      drive(1'b0, 12'h008, 3'd4, 0);
      check("R10 type unchanged", rsp_rdata, ((FIRST) << 16) | N);
      idle();

      // R11: stays set across idle cycles and good traffic
      repeat (5) idle();
      drive(1'b1, 12'h040, 3'd4, 32'(FIRST));
      idle();
      check("R11 sticky", 32'(access_err), 1);
      do_reset();
      check("R11 reset clears", 32'(access_err), 0);

      finish_run();
   end

endmodule